// File: doc/BRIEF.md
# Multidrop Serial Port with Address-Flag Frames

This block is an asynchronous serial transmitter and receiver for a line shared by many nodes. Each character has one extra flag bit that marks it as a node address or as ordinary data. The transmit side sends data characters by default. When software raises a one-shot wake request, the next character that enters the shifter goes out as an address character. The receive side can be put to sleep. While asleep it throws away data characters without raising any event. An address character still reaches the receive queue, so software can compare the address and decide whether to leave sleep.

Both directions have a small FIFO, and each FIFO can be emptied on its own without touching the character in flight. Each receive entry keeps the address flag next to the data byte, so the reader always knows what kind of character it has. A loopback control connects the transmitter to the receiver inside the block and holds the external transmit pin high, so one node can exercise the whole protocol by itself. The bit period is a plain cycle count on an input port.

Top module: `mp_uart`

## Requirements
- R1: A frame is a low start bit, then 8 data bits sent least significant bit first, then the address flag bit (1 = address, 0 = data), then a high stop bit. Each bit lasts `bit_div` clock cycles, and the receiver samples each bit at its middle.
- R2: A pulse on `tx_wake_req` sets `tx_wake_pend`. The next character loaded into the transmit shifter carries address flag 1, and `tx_wake_pend` clears when that load happens. All other characters carry flag 0.
- R3: While `sleep_en` is 1, a received frame whose address flag is 0 is discarded and does not enter the receive FIFO.
- R4: While `sleep_en` is 1, a received frame whose address flag is 1 is stored with `rx_is_addr` = 1. When `sleep_en` is 0, every valid frame is stored.
- R5: `rx_data` and `rx_is_addr` always show the oldest receive entry. A one-cycle `rx_rd` removes it, and characters come out in arrival order.
- R6: When `loopback` is 1, the transmit serial stream feeds the receiver inside the block, `rxd` is ignored, and `txd` stays high.
- R7: Both FIFOs hold 4 entries and drive full and empty flags, which are never both 1. A `tx_wr` while `tx_full` is 1 is ignored.
- R8: A frame that is accepted while the receive FIFO is full is lost and sets `rx_overrun`. The flag stays set until a receive FIFO reset or a module reset.
- R9: `tx_fifo_clr` empties only the transmit FIFO. A character already in the transmit shifter is still sent in full.
- R10: `rx_fifo_clr` empties the receive FIFO and clears `rx_overrun`.
- R11: A frame whose stop bit is sampled low is discarded.
- R12: `rst_n` low empties both FIFOs, stops both shifters, clears `tx_wake_pend` and `rx_overrun`, and holds `txd` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low module reset |
| loopback | input | 1 | Route the transmitter to the receiver inside the block |
| bit_div | input | 16 | Clock cycles per serial bit (at least 2) |
| sleep_en | input | 1 | Receiver sleeps past data frames |
| tx_wake_req | input | 1 | Pulse: next character goes out as an address |
| tx_wr | input | 1 | Write `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Character to transmit |
| tx_fifo_clr | input | 1 | Empty the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_wake_pend | output | 1 | A wake request is waiting for the next load |
| rx_rd | input | 1 | Remove the oldest receive entry |
| rx_fifo_clr | input | 1 | Empty the receive FIFO |
| rx_data | output | 8 | Oldest received data byte |
| rx_is_addr | output | 1 | Address flag of the oldest received entry |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_overrun | output | 1 | Sticky: a character was lost to a full receive FIFO |
| rxd | input | 1 | External serial input |
| txd | output | 1 | External serial output |

## Verification
The bench builds the block with its default FIFO depth of 4 and drives a bit period of 4 clocks. With these values a whole frame takes 44 cycles. A burst of eight writes then fills the transmit queue and overruns the receive queue in a few hundred cycles. Most traffic goes through the loopback path, so sleep, wake and the FIFO resets can all be exercised from one node. Frames are also driven by hand on `rxd` to produce a bad stop bit, and `txd` is sampled bit by bit to confirm the frame layout.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_LEN  = DATA_BITS + 3;   // start, data, flag, stop
  localparam int RX_SAMPLES = DATA_BITS + 2;   // data, flag, stop

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

  // Serial image of one character, bit 0 leaves first.
  function automatic logic [FRAME_LEN-1:0] make_frame(input logic [DATA_BITS-1:0] d,
                                                      input logic addr);
    return {1'b1, addr, d, 1'b0};
  endfunction

  // Rx accepts a frame when stop is high and the sleep rule lets it through.
  function automatic logic frame_accept(input logic stop_ok, input logic addr,
                                        input logic sleeping);
    return stop_ok && (!sleeping || addr);
  endfunction
endpackage

// File: rtl/mpu_fifo.sv
module mpu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/mpu_tx.sv
module mpu_tx
  import mpu_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     bit_div,
  input  logic                 fifo_empty,
  input  logic [DATA_BITS-1:0] fifo_data,
  input  logic                 wake_pend,
  output logic                 load,
  output logic                 line
);
  localparam logic [3:0] LAST_BIT = 4'(FRAME_LEN - 1);

  logic                 busy;
  logic [FRAME_LEN-1:0] sh;
  logic [3:0]           bit_idx;
  logic [DIV_W-1:0]     tick;

  assign load = !busy && !fifo_empty;
  assign line = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sh      <= '1;
      bit_idx <= '0;
      tick    <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      sh      <= make_frame(fifo_data, wake_pend);
      bit_idx <= '0;
      tick    <= '0;
    end else if (busy) begin
      if (tick == bit_div - 1'b1) begin
        tick <= '0;
        sh   <= {1'b1, sh[FRAME_LEN-1:1]};
        if (bit_idx == LAST_BIT) busy <= 1'b0;
        else                     bit_idx <= bit_idx + 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpu_rx.sv
module mpu_rx
  import mpu_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     bit_div,
  input  logic                 line_in,
  output logic                 frame_done,
  output logic [DATA_BITS-1:0] frame_data,
  output logic                 frame_addr,
  output logic                 frame_stop
);
  localparam logic [3:0] LAST_SAMPLE = 4'(RX_SAMPLES - 1);

  rx_state_t             state;
  logic                  s1, s2;
  logic [RX_SAMPLES-1:0] sh;
  logic [DIV_W-1:0]      tick, half;
  logic [3:0]            idx;
  logic                  done_q;

  assign half       = bit_div >> 1;
  assign frame_done = done_q;
  assign frame_data = sh[DATA_BITS-1:0];
  assign frame_addr = sh[DATA_BITS];
  assign frame_stop = sh[DATA_BITS+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      sh     <= '0;
      tick   <= '0;
      idx    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          tick <= '0;
          if (!s2) state <= RX_START;
        end
        RX_START: begin
          if (tick == half - 1'b1) begin
            tick  <= '0;
            idx   <= '0;
            state <= s2 ? RX_IDLE : RX_BITS;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        RX_BITS: begin
          if (tick == bit_div - 1'b1) begin
            tick <= '0;
            sh   <= {s2, sh[RX_SAMPLES-1:1]};
            if (idx == LAST_SAMPLE) begin
              state  <= RX_IDLE;
              done_q <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mp_uart.sv
module mp_uart
  import mpu_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loopback,
  input  logic [DIV_W-1:0] bit_div,
  input  logic             sleep_en,
  input  logic             tx_wake_req,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  input  logic             tx_fifo_clr,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             tx_wake_pend,
  input  logic             rx_rd,
  input  logic             rx_fifo_clr,
  output logic [7:0]       rx_data,
  output logic             rx_is_addr,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rx_overrun,
  input  logic             rxd,
  output logic             txd
);
  // Named internal events, used by the checker.
  logic                 tx_load;
  logic                 tx_line;
  logic [DATA_BITS-1:0] tx_head;
  logic                 rx_line;
  logic                 rx_frame_done;
  logic [DATA_BITS-1:0] rx_frm_data;
  logic                 rx_frm_addr;
  logic                 rx_stop_ok;
  logic                 rx_push;
  logic [DATA_BITS:0]   rx_head;
  logic                 wake_q;
  logic                 ovr_q;
  logic                 txd_q;

  assign rx_line      = loopback ? tx_line : rxd;
  assign rx_push      = rx_frame_done && frame_accept(rx_stop_ok, rx_frm_addr, sleep_en);
  assign tx_wake_pend = wake_q;
  assign rx_overrun   = ovr_q;
  assign txd          = txd_q;
  assign rx_data      = rx_head[DATA_BITS-1:0];
  assign rx_is_addr   = rx_head[DATA_BITS];

  mpu_fifo #(.W(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_fifo_clr),
    .push(tx_wr), .pop(tx_load), .din(tx_data), .dout(tx_head),
    .full(tx_full), .empty(tx_empty)
  );

  mpu_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_div(bit_div),
    .fifo_empty(tx_empty), .fifo_data(tx_head), .wake_pend(wake_q),
    .load(tx_load), .line(tx_line)
  );

  mpu_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_div(bit_div), .line_in(rx_line),
    .frame_done(rx_frame_done), .frame_data(rx_frm_data),
    .frame_addr(rx_frm_addr), .frame_stop(rx_stop_ok)
  );

  mpu_fifo #(.W(DATA_BITS + 1), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_fifo_clr),
    .push(rx_push), .pop(rx_rd), .din({rx_frm_addr, rx_frm_data}), .dout(rx_head),
    .full(rx_full), .empty(rx_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      ovr_q  <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      wake_q <= (wake_q && !tx_load) || tx_wake_req;
      if (rx_fifo_clr)             ovr_q <= 1'b0;
      else if (rx_push && rx_full) ovr_q <= 1'b1;
      txd_q <= loopback ? 1'b1 : tx_line;
    end
  end
endmodule

// File: rtl/mp_uart_checker.sv
module mp_uart_checker (
  input logic clk,
  input logic rst_n,
  input logic loopback,
  input logic txd,
  input logic sleep_en,
  input logic tx_wake_req,
  input logic tx_wake_pend,
  input logic tx_load,
  input logic tx_wr,
  input logic tx_fifo_clr,
  input logic tx_full,
  input logic tx_empty,
  input logic rx_frame_done,
  input logic rx_frm_addr,
  input logic rx_stop_ok,
  input logic rx_push,
  input logic rx_full,
  input logic rx_empty,
  input logic rx_overrun
);
  assert_wake_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !tx_wake_req |=> !tx_wake_pend);

  assert_sleep_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_done && sleep_en && !rx_frm_addr |-> !rx_push);

  assert_addr_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_done && rx_stop_ok && rx_frm_addr |-> rx_push);

  assert_loop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loopback) |-> txd);

  assert_full_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && tx_wr && !tx_load && !tx_fifo_clr |=> tx_full);

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty));

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_push && rx_full));

  assert_bad_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_done && !rx_stop_ok |-> !rx_push);
endmodule

bind mp_uart mp_uart_checker u_mp_uart_checker (
  .clk(clk), .rst_n(rst_n), .loopback(loopback), .txd(txd), .sleep_en(sleep_en),
  .tx_wake_req(tx_wake_req), .tx_wake_pend(tx_wake_pend), .tx_load(tx_load),
  .tx_wr(tx_wr), .tx_fifo_clr(tx_fifo_clr), .tx_full(tx_full), .tx_empty(tx_empty),
  .rx_frame_done(rx_frame_done), .rx_frm_addr(rx_frm_addr), .rx_stop_ok(rx_stop_ok),
  .rx_push(rx_push), .rx_full(rx_full), .rx_empty(rx_empty), .rx_overrun(rx_overrun)
);

// File: tb/mp_uart_bench.sv
module mp_uart_bench;
  localparam int DIV   = 4;
  localparam int FRAME = 11 * DIV;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loopback = 1'b1;
  logic [15:0] bit_div = 16'(DIV);
  logic sleep_en = 1'b0, tx_wake_req = 1'b0, tx_wr = 1'b0, tx_fifo_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic rx_rd = 1'b0, rx_fifo_clr = 1'b0, rxd = 1'b1;
  logic tx_full, tx_empty, tx_wake_pend, rx_is_addr, rx_full, rx_empty, rx_overrun, txd;
  logic [7:0] rx_data;

  int checks = 0, failures = 0, loop_err = 0, flag_err = 0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];
  bit model_ovr = 1'b0;

  always #2 clk = ~clk;

  mp_uart u_mp_uart (
    .clk(clk), .rst_n(rst_n), .loopback(loopback), .bit_div(bit_div),
    .sleep_en(sleep_en), .tx_wake_req(tx_wake_req), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_fifo_clr(tx_fifo_clr), .tx_full(tx_full), .tx_empty(tx_empty),
    .tx_wake_pend(tx_wake_pend), .rx_rd(rx_rd), .rx_fifo_clr(rx_fifo_clr),
    .rx_data(rx_data), .rx_is_addr(rx_is_addr), .rx_full(rx_full), .rx_empty(rx_empty),
    .rx_overrun(rx_overrun), .rxd(rxd), .txd(txd)
  );

  // Per-clock comparison of the invariants the model states.
  always @(negedge clk) begin
    if (rst_n) begin
      if (loopback && txd !== 1'b1) loop_err++;
      if ((tx_full && tx_empty) || (rx_full && rx_empty)) flag_err++;
      if (rx_overrun !== model_ovr && rx_overrun === 1'b1 && !model_ovr) flag_err++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural receive model: what should land in the rx queue.
  task automatic model_rx(input logic [7:0] d, input logic a);
    if (sleep_en && !a) return;
    if (exp_q.size() >= DEPTH) model_ovr = 1'b1;
    else exp_q.push_back({a, d});
  endtask

  task automatic send(input logic [7:0] d, input bit wake, input bit to_model);
    if (wake) begin
      tx_wake_req = 1'b1;
      tick(1);
      tx_wake_req = 1'b0;
    end
    tx_data = d;
    tx_wr = 1'b1;
    tick(1);
    tx_wr = 1'b0;
    if (to_model) model_rx(d, wake);
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() > 0) begin
      logic [8:0] e;
      e = exp_q.pop_front();
      check_eq({tag, " empty"}, int'(rx_empty), 0);
      check_eq({tag, " data"}, int'(rx_data), int'(e[7:0]));
      check_eq({tag, " addr flag"}, int'(rx_is_addr), int'(e[8]));
      rx_rd = 1'b1;
      tick(1);
      rx_rd = 1'b0;
    end
    check_eq({tag, " drained"}, int'(rx_empty), 1);
  endtask

  task automatic drive_rx(input logic [7:0] d, input logic a, input logic stop);
    logic [10:0] f;
    f = {stop, a, d, 1'b0};
    for (int k = 0; k < 11; k++) begin
      rxd = f[k];
      tick(DIV);
    end
    rxd = 1'b1;
    tick(2 * DIV);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [10:0] f;
    tick(3);
    // R12 reset state
    check_eq("R12 tx_empty at reset", int'(tx_empty), 1);
    check_eq("R12 rx_empty at reset", int'(rx_empty), 1);
    check_eq("R12 txd at reset", int'(txd), 1);
    check_eq("R12 wake at reset", int'(tx_wake_pend), 0);
    rst_n = 1'b1;
    tick(2);

    // R5 plain data through loopback
    send(8'hA5, 0, 1);
    send(8'h3C, 0, 1);
    tick(2 * FRAME + 30);
    drain("R5 loop data");

    // R2 wake pending then cleared on load
    tx_wake_req = 1'b1; tick(1); tx_wake_req = 1'b0;
    check_eq("R2 pend set", int'(tx_wake_pend), 1);
    tx_data = 8'h12; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
    model_rx(8'h12, 1);
    tick(3);
    check_eq("R2 pend cleared", int'(tx_wake_pend), 0);
    send(8'h34, 0, 1);
    tick(2 * FRAME + 30);
    drain("R2 addr then data");

    // R3 R4 sleep behaviour
    sleep_en = 1'b1;
    send(8'h55, 0, 1);
    send(8'h07, 1, 1);
    send(8'h66, 0, 1);
    tick(3 * FRAME + 30);
    drain("R3 R4 sleep");
    sleep_en = 1'b0;
    send(8'h99, 0, 1);
    tick(FRAME + 30);
    drain("R4 awake data");

    // R7 R8 R10 full tx queue, rx overrun, rx queue reset
    for (int i = 0; i < 8; i++) begin
      tx_data = 8'(8'h40 + i);
      tx_wr = 1'b1;
      tick(1);
      if (i < 5) model_rx(8'(8'h40 + i), 0);
    end
    tx_wr = 1'b0;
    check_eq("R7 tx_full", int'(tx_full), 1);
    tick(5 * FRAME + 40);
    check_eq("R7 tx drained", int'(tx_empty), 1);
    check_eq("R8 rx_full", int'(rx_full), 1);
    drain("R7 R8 first four");
    check_eq("R8 overrun sticky", int'(rx_overrun), int'(model_ovr));
    rx_fifo_clr = 1'b1; tick(1); rx_fifo_clr = 1'b0;
    model_ovr = 1'b0;
    check_eq("R10 overrun cleared", int'(rx_overrun), 0);
    send(8'hC1, 0, 1);
    send(8'hC2, 0, 1);
    tick(2 * FRAME + 30);
    rx_fifo_clr = 1'b1; tick(1); rx_fifo_clr = 1'b0;
    exp_q.delete();
    check_eq("R10 rx cleared", int'(rx_empty), 1);

    // R9 tx queue reset keeps the shifter character
    tx_data = 8'hB1; tx_wr = 1'b1; tick(1);
    tx_data = 8'hB2; tick(1);
    tx_data = 8'hB3; tick(1);
    tx_wr = 1'b0;
    model_rx(8'hB1, 0);
    tick(10);
    tx_fifo_clr = 1'b1; tick(1); tx_fifo_clr = 1'b0;
    check_eq("R9 tx emptied", int'(tx_empty), 1);
    tick(3 * FRAME + 30);
    drain("R9 in-flight kept");

    // R1 bit layout on txd
    loopback = 1'b0;
    send(8'h5A, 1, 0);
    for (int w = 0; w < 20 && txd; w++) tick(1);
    tick(DIV / 2);
    f = {1'b1, 1'b1, 8'h5A, 1'b0};
    for (int k = 0; k < 11; k++) begin
      check_eq($sformatf("R1 txd bit %0d", k), int'(txd), int'(f[k]));
      tick(DIV);
    end
    tick(DIV);
    check_eq("R6 rxd ignored in loopback earlier", int'(rx_empty), 1);

    // R11 framing error, then a good external frame (R1 receive side)
    drive_rx(8'hF0, 1, 0);
    tick(4);
    check_eq("R11 bad stop dropped", int'(rx_empty), 1);
    drive_rx(8'h0F, 0, 1);
    model_rx(8'h0F, 0);
    tick(4);
    drain("R1 R11 external frame");

    // R6 loopback ignores rxd
    loopback = 1'b1;
    rxd = 1'b0;
    tick(3 * FRAME);
    rxd = 1'b1;
    check_eq("R6 rxd ignored", int'(rx_empty), 1);

    // R12 reset mid-frame
    loopback = 1'b0;
    send(8'hE1, 0, 0);
    send(8'hE2, 0, 0);
    tick(8);
    rst_n = 1'b0;
    tick(2);
    check_eq("R12 txd high in reset", int'(txd), 1);
    check_eq("R12 tx emptied", int'(tx_empty), 1);
    rst_n = 1'b1;
    tick(2 * FRAME);
    check_eq("R12 nothing resent", int'(txd), 1);
    check_eq("R12 tx stays empty", int'(tx_empty), 1);
    check_eq("R12 rx empty", int'(rx_empty), 1);

    check_eq("R6 txd idle during loopback", loop_err, 0);
    check_eq("R7 R8 flag invariants", flag_err, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule